// File: doc/BRIEF.md
# Shared-Cache Miss Classifier Monitor

This monitor sits next to a shared last-level cache used by several processors and sorts every access outcome into one of four kinds: a hit, a compulsory miss, an intra-processor miss (the block was pushed out earlier by the same processor that now misses on it) or an inter-processor miss (the block was pushed out by a different processor). It watches two streams. The access stream carries the requesting processor id, the block address and the cache's hit/miss outcome. The eviction stream carries the address of a block leaving the cache and the id of the processor whose reference forced it out.

For each block it tracks, the monitor keeps a life-cycle record: resident (Referenced) or evicted (Replaced), and for an evicted block, the id of the processor that evicted it. The records live in a small fully associative history table. An address missing from the table counts as never referenced. When the table is full, a new address takes the slot that was accessed least recently. Each accepted access yields a one-cycle result pulse with a class code. Three saturating counters keep the totals per miss class. The cache, its memory traffic and its replacement choices belong to other logic.

Both input streams use valid/ready. The monitor holds ready low only while reset is active. From the first clock after reset it keeps ready high and never applies back-pressure, so a beat is taken on every cycle where valid and ready are both high. The result output is a plain pulse with no ready: an observer that cannot take a result loses it.

Top module: `scm_miss_classifier`

## Requirements
- R1: While rst_n is low, acc_ready, evt_ready and res_valid are 0 and all three counters read 0. From the first clock edge with rst_n high, acc_ready and evt_ready read 1 from then on.
- R2: Each accepted access gives exactly one res_valid pulse, visible after the next rising edge. No pulse appears on a cycle with no accepted access, including cycles that carry only an eviction.
- R3: An access reported as a hit by the cache gives res_code 2'b00 and changes no counter. Afterwards its address is tracked as Referenced.
- R4: A miss to an address not in the table gives res_code 2'b01 (compulsory), and the address is then tracked as Referenced.
- R5: An eviction of a tracked Referenced address moves it to Replaced and stores evt_pid as the evictor. An eviction of an untracked address, or of one already Replaced, changes nothing.
- R6: A miss to a Replaced address whose stored evictor equals acc_pid gives res_code 2'b10 (intra), and the address returns to Referenced.
- R7: A miss to a Replaced address whose stored evictor differs from acc_pid gives res_code 2'b11 (inter), and the address returns to Referenced.
- R8: A miss to an address still tracked as Referenced (no eviction was seen for it) has no evictor to compare, so it gives res_code 2'b01.
- R9: When an eviction and an access are accepted in the same cycle, the eviction takes effect first, so the access is classified against the state the eviction leaves.
- R10: The table holds ENTRIES addresses. Allocating into a full table drops the address whose last access is oldest (evictions do not count as use). A dropped address is then treated as never referenced.
- R11: cnt_comp, cnt_intra and cnt_inter each count their class (codes 01, 10, 11), CNT_W bits wide, and hold at all ones instead of wrapping. They update on the same edge as the result pulse.
- R12: No address occupies more than one table slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access beat present |
| acc_ready | output | 1 | Monitor accepts access beats |
| acc_pid | input | PID_W | Requesting processor id |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_hit | input | 1 | Cache outcome: 1 hit, 0 miss |
| evt_valid | input | 1 | Eviction beat present |
| evt_ready | output | 1 | Monitor accepts eviction beats |
| evt_pid | input | PID_W | Processor whose reference caused the eviction |
| evt_addr | input | ADDR_W | Address of the evicted block |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 2 | 00 hit, 01 compulsory, 10 intra, 11 inter |
| cnt_comp | output | CNT_W | Saturating count of compulsory misses |
| cnt_intra | output | CNT_W | Saturating count of intra-processor misses |
| cnt_inter | output | CNT_W | Saturating count of inter-processor misses |

## Verification
Directed sequences take one address through each life-cycle path: cold miss, hit, a miss with no eviction seen, eviction then a miss by the same processor and by another, double eviction, and eviction of an untracked address. Comparing the codes separates the intra/inter decision from the "no evictor recorded" case. A same-cycle eviction plus access shows whether the eviction takes effect before the lookup or after it. Filling the table with hits and then missing on the oldest and the newest address checks which slot is replaced. A long random mix of processors, a 24-address pool larger than the table, random hit flags and random overlapping evictions is compared against a timestamp-based reference model. A narrow counter width drives the counters into saturation.

// File: rtl/scm_pkg.sv
package scm_pkg;

  // Result encoding on res_code; bit patterns are part of the interface.
  typedef enum logic [1:0] {
    CLS_HIT   = 2'b00,
    CLS_COMP  = 2'b01,
    CLS_INTRA = 2'b10,
    CLS_INTER = 2'b11
  } cls_e;

  localparam int unsigned NUM_MISS_CLASSES = 3;

endpackage

// File: rtl/scm_sat_counter.sv
module scm_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (inc && (q != TOP)) begin
      q <= q + 1'b1;
    end
  end

endmodule

// File: rtl/scm_classify.sv
module scm_classify
  import scm_pkg::*;
#(
  parameter int unsigned PID_W = 2
) (
  input  logic             hit,
  input  logic             found,
  input  logic             repl,
  input  logic [PID_W-1:0] evictor,
  input  logic [PID_W-1:0] pid,
  output cls_e             cls
);

  always_comb begin
    if (hit) begin
      cls = CLS_HIT;
    end else if (!found || !repl) begin
      // untracked, or resident with no recorded evictor
      cls = CLS_COMP;
    end else if (evictor == pid) begin
      cls = CLS_INTRA;
    end else begin
      cls = CLS_INTER;
    end
  end

endmodule

// File: rtl/scm_hist_table.sv
module scm_hist_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned PID_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_fire,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic [PID_W-1:0]   evt_pid,
  input  logic               acc_fire,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               lkp_found,
  output logic               lkp_repl,
  output logic [PID_W-1:0]   lkp_evictor,
  output logic [ENTRIES-1:0] match
);

  localparam int unsigned AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

  // slot storage
  logic [ENTRIES-1:0] s_vld;
  logic [ENTRIES-1:0] s_repl;
  logic [ADDR_W-1:0]  s_addr [ENTRIES];
  logic [PID_W-1:0]   s_evp  [ENTRIES];
  logic [AGE_W-1:0]   s_age  [ENTRIES];

  // view after this cycle's eviction
  logic [ENTRIES-1:0] ev_match;
  logic [ENTRIES-1:0] pv_repl;
  logic [PID_W-1:0]   pv_evp [ENTRIES];

  logic [ENTRIES-1:0] victim;
  logic [ENTRIES-1:0] touch;
  logic [AGE_W-1:0]   touch_age;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ev_match[i] = evt_fire && s_vld[i] && (s_addr[i] == evt_addr);
      match[i]    = s_vld[i] && (s_addr[i] == acc_addr);
      victim[i]   = (s_age[i] == AGE_OLDEST);
      pv_repl[i]  = s_repl[i] | ev_match[i];
      pv_evp[i]   = (ev_match[i] && !s_repl[i]) ? evt_pid : s_evp[i];
    end
  end

  assign lkp_found = |match;
  assign touch     = lkp_found ? match : victim;

  always_comb begin
    lkp_repl    = 1'b0;
    lkp_evictor = '0;
    touch_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lkp_repl    = lkp_repl | pv_repl[i];
        lkp_evictor = lkp_evictor | pv_evp[i];
      end
      if (touch[i]) begin
        touch_age = touch_age | s_age[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld  <= '0;
      s_repl <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        s_addr[i] <= '0;
        s_evp[i]  <= '0;
        s_age[i]  <= AGE_W'(ENTRIES - 1 - i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        s_repl[i] <= pv_repl[i];
        s_evp[i]  <= pv_evp[i];
        if (acc_fire) begin
          if (touch[i]) begin
            s_vld[i]  <= 1'b1;
            s_addr[i] <= acc_addr;
            s_repl[i] <= 1'b0;
            s_age[i]  <= '0;
          end else if (s_age[i] < touch_age) begin
            s_age[i] <= s_age[i] + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/scm_miss_classifier.sv
module scm_miss_classifier
  import scm_pkg::*;
#(
  parameter int unsigned NUM_PROC = 4,
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PID_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [PID_W-1:0]  acc_pid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_hit,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [PID_W-1:0]  evt_pid,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [CNT_W-1:0]  cnt_comp,
  output logic [CNT_W-1:0]  cnt_intra,
  output logic [CNT_W-1:0]  cnt_inter
);

  logic rdy_q;
  logic acc_fire;
  logic evt_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign acc_ready = rdy_q;
  assign evt_ready = rdy_q;
  assign acc_fire  = acc_valid && rdy_q;
  assign evt_fire  = evt_valid && rdy_q;

  logic               lkp_found;
  logic               lkp_repl;
  logic [PID_W-1:0]   lkp_evictor;
  logic [ENTRIES-1:0] tab_match;

  scm_hist_table #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .PID_W  (PID_W)
  ) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_fire   (evt_fire),
    .evt_addr   (evt_addr),
    .evt_pid    (evt_pid),
    .acc_fire   (acc_fire),
    .acc_addr   (acc_addr),
    .lkp_found  (lkp_found),
    .lkp_repl   (lkp_repl),
    .lkp_evictor(lkp_evictor),
    .match      (tab_match)
  );

  cls_e cls_d;

  scm_classify #(.PID_W(PID_W)) u_cls (
    .hit    (acc_hit),
    .found  (lkp_found),
    .repl   (lkp_repl),
    .evictor(lkp_evictor),
    .pid    (acc_pid),
    .cls    (cls_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= CLS_HIT;
    end else begin
      res_valid <= acc_fire;
      if (acc_fire) res_code <= cls_d;
    end
  end

  logic [CNT_W-1:0] cnt_q [NUM_MISS_CLASSES];

  for (genvar k = 0; k < NUM_MISS_CLASSES; k++) begin : g_cnt
    scm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (acc_fire && (cls_d == cls_e'(k + 1))),
      .q    (cnt_q[k])
    );
  end

  assign cnt_comp  = cnt_q[0];
  assign cnt_intra = cnt_q[1];
  assign cnt_inter = cnt_q[2];

endmodule

// File: rtl/scm_miss_classifier_chk.sv
module scm_miss_classifier_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_ready,
  input logic               acc_hit,
  input logic               evt_ready,
  input logic               res_valid,
  input logic [1:0]         res_code,
  input logic [CNT_W-1:0]   cnt_comp,
  input logic [CNT_W-1:0]   cnt_intra,
  input logic [CNT_W-1:0]   cnt_inter,
  input logic [ENTRIES-1:0] tab_match
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (acc_ready && evt_ready)); // R1

  AST_PULSE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> res_valid); // R2

  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |=> !res_valid); // R2

  AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_hit) |=> (res_code == 2'b00)); // R3

  AST_COMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b01) |->
      (cnt_comp == (($past(cnt_comp) == TOP) ? TOP : $past(cnt_comp) + 1'b1))); // R11

  AST_COMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_code == 2'b01) |-> $stable(cnt_comp)); // R11

  AST_INTRA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b10) |->
      (cnt_intra == (($past(cnt_intra) == TOP) ? TOP : $past(cnt_intra) + 1'b1))); // R11

  AST_INTRA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_code == 2'b10) |-> $stable(cnt_intra)); // R11

  AST_INTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'b11) |->
      (cnt_inter == (($past(cnt_inter) == TOP) ? TOP : $past(cnt_inter) + 1'b1))); // R11

  AST_INTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_code == 2'b11) |-> $stable(cnt_inter)); // R11

  AST_UNIQUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tab_match)); // R12

endmodule

bind scm_miss_classifier scm_miss_classifier_chk #(
  .CNT_W  (CNT_W),
  .ENTRIES(ENTRIES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_ready(acc_ready),
  .acc_hit  (acc_hit),
  .evt_ready(evt_ready),
  .res_valid(res_valid),
  .res_code (res_code),
  .cnt_comp (cnt_comp),
  .cnt_intra(cnt_intra),
  .cnt_inter(cnt_inter),
  .tab_match(tab_match)
);

// File: tb/scm_miss_classifier_tb.sv
`timescale 1ns/1ps
module scm_miss_classifier_tb;

  localparam int NP    = 4;
  localparam int AW    = 26;
  localparam int NE    = 16;
  localparam int CW    = 8;
  localparam int PW    = 2;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic [PW-1:0] acc_pid = '0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_hit = 1'b0;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic [PW-1:0] evt_pid = '0;
  logic [AW-1:0] evt_addr = '0;
  logic          res_valid;
  logic [1:0]    res_code;
  logic [CW-1:0] cnt_comp, cnt_intra, cnt_inter;

  always #4 clk = ~clk;

  scm_miss_classifier #(
    .NUM_PROC(NP), .ADDR_W(AW), .ENTRIES(NE), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_pid(acc_pid),
    .acc_addr(acc_addr), .acc_hit(acc_hit),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_pid(evt_pid),
    .evt_addr(evt_addr),
    .res_valid(res_valid), .res_code(res_code),
    .cnt_comp(cnt_comp), .cnt_intra(cnt_intra), .cnt_inter(cnt_inter)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit          m_vld  [NE];
  bit          m_repl [NE];
  logic [AW-1:0] m_addr [NE];
  int          m_evp  [NE];
  longint      m_time [NE];
  longint      now = 0;
  int          e_cnt  [3];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (m_vld[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic model(input bit av, input int pid, input logic [AW-1:0] addr,
                       input bit hit, input bit ev, input int epid,
                       input logic [AW-1:0] eaddr,
                       output int code, output string tag);
    int idx;
    code = 0;
    tag  = "R2";
    if (ev) begin
      idx = find(eaddr);
      if (idx >= 0 && !m_repl[idx]) begin
        m_repl[idx] = 1;
        m_evp[idx]  = epid;
      end
    end
    if (av) begin
      idx = find(addr);
      if (hit) begin code = 0; tag = "R3"; end
      else if (idx < 0) begin code = 1; tag = "R4"; end
      else if (!m_repl[idx]) begin code = 1; tag = "R8"; end
      else if (m_evp[idx] == pid) begin code = 2; tag = "R6"; end
      else begin code = 3; tag = "R7"; end
      if (idx < 0) begin
        longint best = 0;
        for (int i = 0; i < NE; i++) begin
          if (!m_vld[i]) begin idx = i; break; end
          if (idx < 0 || m_time[i] < best) begin idx = i; best = m_time[i]; end
        end
        m_vld[idx]  = 1;
        m_addr[idx] = addr;
      end
      m_repl[idx] = 0;
      now++;
      m_time[idx] = now;
      if (code != 0 && e_cnt[code-1] < CMAX) e_cnt[code-1]++;
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input bit av, input int pid, input logic [AW-1:0] addr,
                      input bit hit, input bit ev, input int epid,
                      input logic [AW-1:0] eaddr, input string tg);
    int    code;
    string mtag;
    acc_valid = av;  acc_pid = PW'(pid); acc_addr = addr; acc_hit = hit;
    evt_valid = ev;  evt_pid = PW'(epid); evt_addr = eaddr;
    model(av, pid, addr, hit, ev, epid, eaddr, code, mtag);
    @(negedge clk);
    acc_valid = 0; evt_valid = 0;
    chk(res_valid == av, "R2", "res_valid", int'(res_valid), int'(av));
    if (av)
      chk(res_code == 2'(code), (tg != "") ? tg : mtag, "res_code",
          int'(res_code), code);
    chk(cnt_comp  == CW'(e_cnt[0]), "R11", "cnt_comp",  int'(cnt_comp),  e_cnt[0]);
    chk(cnt_intra == CW'(e_cnt[1]), "R11", "cnt_intra", int'(cnt_intra), e_cnt[1]);
    chk(cnt_inter == CW'(e_cnt[2]), "R11", "cnt_inter", int'(cnt_inter), e_cnt[2]);
  endtask

  task automatic acc(input int pid, input logic [AW-1:0] a, input bit hit,
                     input string tg);
    step(1, pid, a, hit, 0, 0, '0, tg);
  endtask

  task automatic evict(input int epid, input logic [AW-1:0] a, input string tg);
    step(0, 0, '0, 0, 1, epid, a, tg);
  endtask

  localparam logic [AW-1:0] A = 26'h100;
  localparam logic [AW-1:0] B = 26'h200;

  initial begin
    void'($urandom(32'd5151));
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_repl[i] = 0; m_addr[i] = '0; m_evp[i] = 0; m_time[i] = 0;
    end
    for (int k = 0; k < 3; k++) e_cnt[k] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(acc_ready == 0, "R1", "acc_ready in reset", int'(acc_ready), 0);
    chk(evt_ready == 0, "R1", "evt_ready in reset", int'(evt_ready), 0);
    chk(res_valid == 0, "R1", "res_valid in reset", int'(res_valid), 0);
    chk(cnt_comp == 0 && cnt_intra == 0 && cnt_inter == 0, "R1", "counters",
        int'(cnt_comp) + int'(cnt_intra) + int'(cnt_inter), 0);
    rst_n = 1;
    @(negedge clk);
    chk(acc_ready == 1 && evt_ready == 1, "R1", "ready after reset",
        int'(acc_ready & evt_ready), 1);

    // directed life-cycle paths
    acc(0, A, 0, "R4");           // cold miss
    acc(1, A, 1, "R3");           // hit
    acc(2, A, 0, "R8");           // miss while resident
    evict(1, A, "R2");            // eviction only: no pulse
    acc(1, A, 0, "R6");           // same processor
    evict(3, A, "R5");
    acc(0, A, 0, "R7");           // different processor
    evict(2, B, "R5");            // untracked: ignored
    acc(2, B, 0, "R5");           // still compulsory
    evict(1, A, "R5");
    evict(2, A, "R5");            // already replaced: ignored
    acc(1, A, 0, "R5");           // evictor stays 1 -> intra
    step(1, 3, A, 0, 1, 3, A, "R9");   // same cycle, same pid -> intra
    step(1, 0, A, 0, 1, 2, A, "R9");   // same cycle, other pid -> inter

    // R10: fill with hits, B becomes least recent and is dropped
    acc(0, A, 1, "R10");
    for (int i = 0; i < 15; i++) acc(i % NP, 26'h300 + AW'(i), 1, "R10");
    evict(2, B, "R10");           // B gone: ignored
    acc(2, B, 0, "R10");          // compulsory, not intra
    evict(1, 26'h30E, "R10");     // newest fill entry kept
    acc(3, 26'h30E, 0, "R10");    // inter

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit av = ($urandom % 8) != 0;
      bit ev = ($urandom % 3) == 0;
      step(av, int'($urandom % NP), 26'h1000 + AW'($urandom % 24),
           ($urandom % 4) == 0, ev, int'($urandom % NP),
           26'h1000 + AW'($urandom % 24), "");
    end

    chk(cnt_comp == CW'(CMAX), "R11", "cnt_comp saturated", int'(cnt_comp), CMAX);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule